// File: doc/BRIEF.md
# Embedded Controller Host Command Port

This block sits between a host processor and the private register space of an embedded controller. The host sees two byte-wide ports, chosen by one address line: a command/status port and a data port. Writing a command byte to the command port starts a short transaction. Later bytes written to the data port supply an address, and for a store also the value. A one-byte output buffer returns results.

Two handshake flags pace the host. The input-buffer-full flag (IBF) is set by every accepted host write. It stays set while the internal sequencer digests the byte. The output-buffer-full flag (OBF) is set when a result waits in the output buffer, and it clears when the host fetches that result. During read and write transactions the block pulses an interrupt request whenever IBF drops or OBF rises, so an interrupt-driven host never has to poll. A burst-enable command is passed on as a one-cycle request to a separate burst supervisor, whose state is mirrored in the status byte.

Top module: `ec_host_port`

## Requirements
- R1: After reset, IBF, OBF, the command-flag bit, `irq`, `burst_req` and `hrdata` are all 0, and a status read returns 0x00 while `burst_active` is 0.
- R2: A host write (`hsel` and `hwr` high) made while IBF is 0 sets IBF on that clock edge. It latches the byte and records the port in status bit 3 (1 = command port, 0 = data port). IBF stays 1 for exactly CONSUME_CYCLES cycles and then clears. A host write made while IBF is 1 is dropped.
- R3: Command 0x80 followed by one data-port byte A reads the internal byte at A into the output buffer. OBF rises on the clock edge after the edge that clears IBF for byte A.
- R4: A host read of the data port (`hcmd`=0) returns the output buffer and clears OBF. A read of the command port returns the status byte and leaves OBF unchanged. Status layout: bit 0 OBF, bit 1 IBF, bit 3 command flag, bit 4 burst mode, all other bits 0.
- R5: Command 0x81 followed by data-port bytes A and then D stores D at internal address A. A later read of A returns D, even when A or D equals a command code.
- R6: Command 0x82 pulses `burst_req` high for exactly one cycle, on the edge that consumes the byte. It raises no interrupt. Status bit 4 follows the `burst_active` input.
- R7: `irq` is high for one cycle after each edge on which IBF falls for a byte of a read or write transaction (the 0x80/0x81 command byte or its address/data byte), and for one cycle after each edge on which OBF rises.
- R8: A command byte consumed in the middle of a transaction abandons that transaction without storing anything. Decoding restarts from the new command.
- R9: An unrecognised command byte, or a data-port byte received outside a transaction, is consumed normally (IBF clears). It changes neither OBF nor the internal memory, and raises no interrupt.
- R10: `hrdata` is registered. It updates one cycle after a read strobe and holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel | input | 1 | Host select |
| hwr | input | 1 | Host write strobe |
| hrd | input | 1 | Host read strobe |
| hcmd | input | 1 | 1 = command/status port, 0 = data port |
| hwdata | input | DATA_W | Host write byte |
| hrdata | output | DATA_W | Registered host read byte |
| irq | output | 1 | Interrupt request pulse toward the host |
| burst_req | output | 1 | One-cycle burst-enable request to the supervisor |
| burst_active | input | 1 | Burst mode state from the supervisor |

## Verification
The store/fetch path is tried with a table of six address/value pairs. The table covers the lowest and highest address, a data-port byte equal to a command code, and the values 0x00, 0xFF and alternating bit patterns. Together these tell apart address truncation, stuck data bits and a data byte mistaken for a command. A per-cycle status trace around one fetch separates the correct order (IBF falls, then OBF rises one edge later, each with its own interrupt) from merged, swapped or missing flag changes. Directed cases follow: a write made while busy, a transaction cut off by a new command, an unknown command, a stray data byte and a burst request. Each of these is judged by later fetches, status reads and pulse counts.

// File: rtl/ec_host_pkg.sv
package ec_host_pkg;

  localparam logic [7:0] CMD_READ  = 8'h80;
  localparam logic [7:0] CMD_WRITE = 8'h81;
  localparam logic [7:0] CMD_BURST = 8'h82;

  localparam int ST_OBF   = 0;
  localparam int ST_IBF   = 1;
  localparam int ST_CMD   = 3;
  localparam int ST_BURST = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RD_ADDR,
    SEQ_WR_ADDR,
    SEQ_WR_DATA
  } seq_state_t;

endpackage

// File: rtl/ec_regfile.sv
module ec_regfile #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/ec_flags.sv
module ec_flags
  import ec_host_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int CONSUME_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_cmd,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd_data,
  input  logic              load_out,
  input  logic [DATA_W-1:0] load_val,
  input  logic              seq_evt,
  input  logic              burst_active,
  output logic              consume,
  output logic [DATA_W-1:0] in_byte,
  output logic              in_is_cmd,
  output logic [DATA_W-1:0] out_byte,
  output logic              ibf,
  output logic              obf,
  output logic              irq,
  output logic [DATA_W-1:0] status
);

  localparam int CNT_W = (CONSUME_CYCLES > 1) ? $clog2(CONSUME_CYCLES) : 1;

  logic accept;
  assign accept = host_wr && !ibf;

  generate
    if (CONSUME_CYCLES <= 1) begin : g_fast
      assign consume = ibf;
    end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (accept) cnt <= CNT_W'(CONSUME_CYCLES - 1);
        else if (ibf && cnt != '0) cnt <= cnt - 1'b1;
      end
      assign consume = ibf && (cnt == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ibf       <= 1'b0;
      obf       <= 1'b0;
      in_byte   <= '0;
      in_is_cmd <= 1'b0;
      out_byte  <= '0;
      irq       <= 1'b0;
    end else begin
      if (accept) begin
        ibf       <= 1'b1;
        in_byte   <= host_wdata;
        in_is_cmd <= host_cmd;
      end else if (consume) begin
        ibf <= 1'b0;
      end
      if (load_out) begin
        obf      <= 1'b1;
        out_byte <= load_val;
      end else if (host_rd_data) begin
        obf <= 1'b0;
      end
      irq <= (consume && seq_evt) || (load_out && !obf);
    end
  end

  always_comb begin
    status           = '0;
    status[ST_OBF]   = obf;
    status[ST_IBF]   = ibf;
    status[ST_CMD]   = in_is_cmd;
    status[ST_BURST] = burst_active;
  end

  AST_WR_SETS_IBF: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !ibf) |=> (ibf && in_is_cmd == $past(host_cmd))); // R2
  AST_IBF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ibf && !consume) |=> ibf); // R2
  AST_OBF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (host_rd_data && !load_out) |=> !obf); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($fell(ibf) || $rose(obf))); // R7

endmodule

// File: rtl/ec_cmd_seq.sv
module ec_cmd_seq
  import ec_host_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              consume,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_is_cmd,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              seq_evt,
  output logic              rd_done,
  output logic              burst_req
);

  seq_state_t        state;
  logic [ADDR_W-1:0] addr_q;
  logic              is_rd_cmd, is_wr_cmd, is_burst_cmd;

  assign is_rd_cmd    = (in_byte[7:0] == CMD_READ);
  assign is_wr_cmd    = (in_byte[7:0] == CMD_WRITE);
  assign is_burst_cmd = (in_byte[7:0] == CMD_BURST);

  always_comb begin
    mem_re    = consume && !in_is_cmd && (state == SEQ_RD_ADDR);
    mem_we    = consume && !in_is_cmd && (state == SEQ_WR_DATA);
    mem_addr  = (state == SEQ_WR_DATA) ? addr_q : in_byte[ADDR_W-1:0];
    mem_wdata = in_byte;
    if (in_is_cmd) seq_evt = consume && (is_rd_cmd || is_wr_cmd);
    else           seq_evt = consume && (state != SEQ_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      addr_q    <= '0;
      rd_done   <= 1'b0;
      burst_req <= 1'b0;
    end else begin
      rd_done   <= mem_re;
      burst_req <= consume && in_is_cmd && is_burst_cmd;
      if (consume) begin
        if (in_is_cmd) begin
          if (is_rd_cmd)      state <= SEQ_RD_ADDR;
          else if (is_wr_cmd) state <= SEQ_WR_ADDR;
          else                state <= SEQ_IDLE;
        end else begin
          case (state)
            SEQ_RD_ADDR: state <= SEQ_IDLE;
            SEQ_WR_ADDR: begin
              addr_q <= in_byte[ADDR_W-1:0];
              state  <= SEQ_WR_DATA;
            end
            SEQ_WR_DATA: state <= SEQ_IDLE;
            default:     state <= SEQ_IDLE;
          endcase
        end
      end
    end
  end

  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we)); // R5
  AST_BURST_PULSE: assert property (@(posedge clk) disable iff (rst)
    burst_req |=> !burst_req); // R6
  AST_CMD_RESTART: assert property (@(posedge clk) disable iff (rst)
    (consume && in_is_cmd) |=> (state != SEQ_WR_DATA)); // R8

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_host_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int DATA_W         = 8,
  parameter int CONSUME_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsel,
  input  logic              hwr,
  input  logic              hrd,
  input  logic              hcmd,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] hrdata,
  output logic              irq,
  output logic              burst_req,
  input  logic              burst_active
);

  logic              host_wr, host_rd, host_rd_data;
  logic              consume, in_is_cmd, ibf, obf, seq_evt, rd_done;
  logic              mem_re, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] in_byte, out_byte, status, mem_wdata, mem_rdata;

  assign host_wr      = hsel && hwr;
  assign host_rd      = hsel && hrd;
  assign host_rd_data = host_rd && !hcmd;

  ec_flags #(.DATA_W(DATA_W), .CONSUME_CYCLES(CONSUME_CYCLES)) u_flags (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_cmd(hcmd), .host_wdata(hwdata),
    .host_rd_data(host_rd_data),
    .load_out(rd_done), .load_val(mem_rdata),
    .seq_evt(seq_evt), .burst_active(burst_active),
    .consume(consume), .in_byte(in_byte), .in_is_cmd(in_is_cmd),
    .out_byte(out_byte), .ibf(ibf), .obf(obf), .irq(irq), .status(status)
  );

  ec_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst),
    .consume(consume), .in_byte(in_byte), .in_is_cmd(in_is_cmd),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .seq_evt(seq_evt),
    .rd_done(rd_done), .burst_req(burst_req)
  );

  ec_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .re(mem_re), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)          hrdata <= '0;
    else if (host_rd) hrdata <= hcmd ? status : out_byte;
  end

  AST_OBF_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
    $rose(obf) |-> $past(mem_re, 2)); // R3
  AST_HRDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(hrdata)); // R10

endmodule

// File: tb/ec_host_port_test.sv
module ec_host_port_test;

  localparam int CONSUME = 3;
  localparam int SETTLE  = CONSUME + 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsel = 1'b0, hwr = 1'b0, hrd = 1'b0, hcmd = 1'b0;
  logic [7:0] hwdata = '0;
  logic [7:0] hrdata;
  logic       irq, burst_req;
  logic       burst_active = 1'b0;

  int errors = 0, checks = 0, irq_cnt = 0, burst_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ec_host_port #(.ADDR_W(8), .DATA_W(8), .CONSUME_CYCLES(CONSUME)) uut (
    .clk(clk), .rst(rst), .hsel(hsel), .hwr(hwr), .hrd(hrd), .hcmd(hcmd),
    .hwdata(hwdata), .hrdata(hrdata), .irq(irq), .burst_req(burst_req),
    .burst_active(burst_active)
  );

  always @(negedge clk) begin
    if (!rst && irq) irq_cnt++;
    if (!rst && burst_req) burst_cnt++;
  end

  // {address, value}
  localparam logic [15:0] VEC [6] = '{
    16'h00_3C, 16'hFF_C3, 16'h30_A5, 16'h5A_00, 16'h81_FF, 16'hC3_5A
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic host_wr(input logic is_cmd, input logic [7:0] b);
    hsel = 1'b1; hwr = 1'b1; hcmd = is_cmd; hwdata = b;
    @(negedge clk);
    hsel = 1'b0; hwr = 1'b0;
  endtask

  task automatic host_rd(input logic is_cmd, output logic [7:0] b);
    hsel = 1'b1; hrd = 1'b1; hcmd = is_cmd;
    @(negedge clk);
    b = hrdata;
    hsel = 1'b0; hrd = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic ec_store(input logic [7:0] a, input logic [7:0] d);
    host_wr(1'b1, 8'h81); settle();
    host_wr(1'b0, a);     settle();
    host_wr(1'b0, d);     settle();
  endtask

  task automatic ec_fetch(input logic [7:0] a, output logic [7:0] d);
    host_wr(1'b1, 8'h80); settle();
    host_wr(1'b0, a);     settle();
    host_rd(1'b0, d);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [7:0] v, v2;
    logic [7:0] st_tr [7];
    logic       iq_tr [7];
    int         i0, b0;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 hrdata", hrdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 burst_req", {7'b0, burst_req}, 8'h00);
    host_rd(1'b1, v);
    chk("R1 status", v, 8'h00);

    // R5 table walk: store every pair, then fetch each
    for (int i = 0; i < 6; i++) ec_store(VEC[i][15:8], VEC[i][7:0]);
    for (int i = 0; i < 6; i++) begin
      ec_fetch(VEC[i][15:8], v);
      chk("R5 readback", v, VEC[i][7:0]);
    end

    // R2 command write busy: status shows IBF and command flag
    host_wr(1'b1, 8'h80);
    host_rd(1'b1, v);
    chk("R2 status after command write", v, 8'h0A);
    settle();

    // R3/R7 per-cycle ordering trace for address byte 0x30
    i0 = irq_cnt;
    host_wr(1'b0, 8'h30);
    hsel = 1'b1; hrd = 1'b1; hcmd = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      st_tr[k] = hrdata;
      iq_tr[k] = irq;
    end
    hsel = 1'b0; hrd = 1'b0;
    chk("R2 IBF held cycle 1", st_tr[1], 8'h02);
    chk("R2 IBF held cycle 3", st_tr[3], 8'h02);
    chk("R2 IBF cleared after CONSUME cycles", st_tr[4], 8'h00);
    chk("R3 OBF set one edge after IBF clear", st_tr[5], 8'h01);
    chk("R4 status read keeps OBF", st_tr[6], 8'h01);
    chk("R7 no irq before IBF falls", {7'b0, iq_tr[2]}, 8'h00);
    chk("R7 irq on IBF fall", {7'b0, iq_tr[3]}, 8'h01);
    chk("R7 irq on OBF rise", {7'b0, iq_tr[4]}, 8'h01);
    chk("R7 irq ends", {7'b0, iq_tr[5]}, 8'h00);
    chk("R7 irq count", 8'(irq_cnt - i0), 8'd2);
    host_rd(1'b0, v);
    chk("R3 fetched value", v, 8'hA5);
    host_rd(1'b1, v2);
    chk("R4 data read clears OBF", v2, 8'h00);

    // R10 hrdata holds with no read
    repeat (3) @(negedge clk);
    chk("R10 hrdata holds", hrdata, 8'h00);
    host_rd(1'b0, v);
    chk("R10 hrdata updates on read", v, 8'hA5);

    // R2 write while busy is dropped
    host_wr(1'b1, 8'h81);
    host_wr(1'b0, 8'h10);
    settle();
    host_wr(1'b0, 8'h20); settle();
    host_wr(1'b0, 8'h77); settle();
    ec_fetch(8'h20, v);
    chk("R2 busy write dropped", v, 8'h77);

    // R8 store cut off by a fetch command
    host_wr(1'b1, 8'h81); settle();
    host_wr(1'b0, 8'h30); settle();
    host_wr(1'b1, 8'h80); settle();
    host_wr(1'b0, 8'h30); settle();
    host_rd(1'b1, v);
    chk("R8 restarted as fetch, OBF set", v, 8'h01);
    host_rd(1'b0, v);
    chk("R8 aborted store left memory", v, 8'hA5);

    // R9 unknown command and stray data byte
    i0 = irq_cnt;
    host_wr(1'b1, 8'h55); settle();
    host_wr(1'b0, 8'h30); settle();
    host_rd(1'b1, v);
    chk("R9 ignored bytes: IBF clear, OBF clear", v, 8'h00);
    chk("R9 no irq", 8'(irq_cnt - i0), 8'd0);
    ec_fetch(8'h30, v);
    chk("R9 memory unchanged", v, 8'hA5);

    // R6 burst request
    i0 = irq_cnt; b0 = burst_cnt;
    host_wr(1'b1, 8'h82); settle();
    chk("R6 one burst_req cycle", 8'(burst_cnt - b0), 8'd1);
    chk("R6 no irq", 8'(irq_cnt - i0), 8'd0);
    burst_active = 1'b1;
    host_rd(1'b1, v);
    chk("R6 status burst bit", v, 8'h18);
    burst_active = 1'b0;
    host_rd(1'b1, v);
    chk("R6 status burst bit clear", v, 8'h08);

    summary();
  end

endmodule